// File: doc/BRIEF.md
# Bit-Serial Registration Code CRC-8 Checker

This block computes the 8-bit CRC of a 64-bit device registration code one bit at a time. The code is made of an 8-bit family code, a 48-bit serial number and an 8-bit CRC. Bits enter least significant bit first: the family code comes first, then the serial number, then the CRC byte. The register starts at zero. After the 56 identity bits it holds the CRC of the code. After all 64 bits it holds zero if the code is intact.

A reader uses the block to qualify a code as it arrives. A one-cycle `done` pulse and a `code_ok` flag report the verdict. A device that sends its own code can use the block the other way. Once the 56 identity bits have been shifted, `tx_phase` rises and `tx_bit` offers the next CRC bit. Feeding `tx_bit` back into `bit_in` sends the CRC out least significant bit first and still ends with a zero residue.

Top module: `rom_id_crc8`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `crc_q`, `bit_cnt`, `done` and `code_ok` to zero on that edge.
- R2: Each bit accepted with `bit_vld` high does the following at the next edge:
  - It forms fb = `crc_q[0]` XOR `bit_in`.
  - It loads `crc_q` with (`crc_q` >> 1) XOR (fb ? 8'h8C : 0). This is the reflected form of x^8+x^5+x^4+1.
  - It increments `bit_cnt`.
- R3: From a zero register, 56 accepted identity bits leave `crc_q` equal to the code's CRC. For example, the bytes 02 1C B8 01 00 00 00, each sent LSB first, give 8'hA2.
- R4: After all 64 bits of a correct code, family 23h included, `crc_q` is 0 and `code_ok` is 1.
- R5: `done` is high for exactly one cycle, the cycle after the 64th bit is accepted. `code_ok` then shows whether the final residue is zero, and it is 0 for a corrupted code.
- R6: `clr` high at an edge zeroes `crc_q`, `bit_cnt`, `done` and `code_ok`. It takes priority over a `bit_vld` in the same cycle.
- R7: A cycle with `bit_vld` low changes neither `crc_q` nor `bit_cnt`. Bits offered once `bit_cnt` has reached 64 are ignored until `clr` or `rst`.
- R8: While `bit_cnt` is from 56 to 63, `tx_phase` is 1 and `tx_bit` equals `crc_q[0]`. Otherwise `tx_phase` is 0. Feeding `tx_bit` back as `bit_in` shifts `crc_q` right by one each step, so the CRC goes out LSB first and `code_ok` ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start a new code; overrides `bit_vld` |
| bit_vld | input | 1 | `bit_in` carries a code bit this cycle |
| bit_in | input | 1 | Serial code bit, LSB first |
| crc_q | output | 8 | CRC shift register |
| bit_cnt | output | 7 | Number of bits accepted, saturating at 64 |
| done | output | 1 | One-cycle pulse after the 64th bit |
| code_ok | output | 1 | Residue was zero at the last completed code |
| tx_phase | output | 1 | CRC bits are due, from bit 56 to bit 63 |
| tx_bit | output | 1 | Next CRC bit to transmit |

## Verification
The assertions check the following on every cycle:
- a clear empties the state;
- the counter never passes 64;
- idle cycles change nothing;
- `done` lasts one cycle and only appears with a full count;
- an accepted verdict implies a zero register;
- a transmitted CRC bit shifts the register right.

The arithmetic itself is only shown by the bench's scenarios:
- the exact CRC value after 56 bits for a known code;
- acceptance of a family 23h code;
- rejection of a flipped bit;
- the CRC bit order when the block sends its own code.

// File: rtl/rom_id_crc8.sv
module rom_id_crc8 #(
  parameter int ID_BITS = 56,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C,
  localparam int TOTAL = ID_BITS + CRC_W,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             done,
  output logic             code_ok,
  output logic             tx_phase,
  output logic             tx_bit
);

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] ID_C   = CNT_W'(ID_BITS);

  logic             fb;
  logic             take;
  logic [CRC_W-1:0] crc_nx;

  assign fb     = crc_q[0] ^ bit_in;
  assign crc_nx = (crc_q >> 1) ^ (fb ? POLY_REFL : '0);
  assign take   = bit_vld && (bit_cnt != FULL_C);

  assign tx_phase = (bit_cnt >= ID_C) && (bit_cnt != FULL_C);
  assign tx_bit   = crc_q[0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q   <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
      code_ok <= 1'b0;
    end else begin
      done <= take && (bit_cnt == LAST_C);
      if (take) begin
        crc_q   <= crc_nx;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_C) code_ok <= (crc_nx == '0);
      end
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == '0) && (bit_cnt == '0) && !done && !code_ok); // R6
  AST_CNT_MAX: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL_C); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !clr) |=> ($stable(crc_q) && $stable(bit_cnt))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
    done |-> (bit_cnt == FULL_C)); // R5
  AST_OK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && code_ok) |-> (crc_q == '0)); // R4
  AST_TX_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (tx_phase && bit_vld && (bit_in == tx_bit) && !clr) |=> (crc_q == ($past(crc_q) >> 1))); // R8

endmodule

// File: tb/tb_rom_id_crc8.sv
module tb_rom_id_crc8;
  logic clk = 1'b0;
  logic rst, clr, bit_vld, bit_in;
  logic [7:0] crc_q;
  logic [6:0] bit_cnt;
  logic done, code_ok, tx_phase, tx_bit;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rom_id_crc8 dut (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
    .crc_q(crc_q), .bit_cnt(bit_cnt), .done(done), .code_ok(code_ok),
    .tx_phase(tx_phase), .tx_bit(tx_bit)
  );

  function automatic logic [7:0] ref_crc(input logic [63:0] w, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ w[i];
      c = (c >> 1) ^ (f ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic do_clear;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset;
    check(crc_q == 0 && bit_cnt == 0, "R1 regs", {crc_q, 1'b0, bit_cnt}, 0);
    check(!done && !code_ok && !tx_phase, "R1 flags", {done, code_ok, tx_phase}, 0);
  endtask

  task automatic t_known;
    logic [63:0] w = 64'hA200_0000_01B8_1C02;
    do_clear();
    for (int i = 0; i < 56; i++) send(w[i]);
    check(crc_q == 8'hA2, "R3 crc after 56", crc_q, 8'hA2);
    check(tx_phase && tx_bit == crc_q[0], "R8 tx_phase", {tx_phase, tx_bit}, {1'b1, crc_q[0]});
    for (int i = 56; i < 63; i++) send(w[i]);
    @(negedge clk); bit_vld = 1'b1; bit_in = w[63];
    @(negedge clk); bit_vld = 1'b0;
    check(done == 1'b1, "R5 done pulse", done, 1);
    check(code_ok && crc_q == 0, "R4 known ok", {code_ok, crc_q}, {1'b1, 8'h00});
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", done, 0);
  endtask

  task automatic t_family(input logic [47:0] ser);
    logic [63:0] w;
    w[55:0] = {ser, 8'h23};
    w[63:56] = ref_crc(w, 56);
    do_clear();
    for (int i = 0; i < 64; i++) send(w[i]);
    check(code_ok && crc_q == 0, "R4 family 23h", {code_ok, crc_q}, {1'b1, 8'h00});
    check(bit_cnt == 64, "R2 count", bit_cnt, 64);
  endtask

  task automatic t_corrupt;
    logic [63:0] w;
    w[55:0] = {48'h0000_00C0_FFEE, 8'h23};
    w[63:56] = ref_crc(w, 56);
    w[17] = ~w[17];
    do_clear();
    for (int i = 0; i < 63; i++) send(w[i]);
    @(negedge clk); bit_vld = 1'b1; bit_in = w[63];
    @(negedge clk); bit_vld = 1'b0;
    check(done == 1'b1 && code_ok == 1'b0, "R5 bad code", {done, code_ok}, 2'b10);
    check(crc_q == ref_crc(w, 64), "R2 residue", crc_q, ref_crc(w, 64));
  endtask

  task automatic t_clear_prio;
    do_clear();
    for (int i = 0; i < 10; i++) send(i[0] ^ i[2]);
    @(negedge clk); clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk); clr = 1'b0; bit_vld = 1'b0;
    check(crc_q == 0 && bit_cnt == 0, "R6 clear priority", {crc_q, 1'b0, bit_cnt}, 0);
  endtask

  task automatic t_ignore;
    logic [7:0] c0;
    logic [63:0] w = 64'h1234_5678_9ABC_DEF1;
    do_clear();
    for (int i = 0; i < 20; i++) send(w[i]);
    c0 = crc_q;
    bit_in = 1'b1;
    repeat (5) @(negedge clk);
    check(crc_q == c0 && bit_cnt == 20, "R7 idle hold", {crc_q, 1'b0, bit_cnt}, {c0, 1'b0, 7'd20});
    check(crc_q == ref_crc(w, 20), "R2 partial", crc_q, ref_crc(w, 20));
    for (int i = 20; i < 64; i++) send(w[i]);
    c0 = crc_q;
    send(1'b1); send(1'b0); send(1'b1);
    check(crc_q == c0 && bit_cnt == 64, "R7 after full", {crc_q, 1'b0, bit_cnt}, {c0, 1'b0, 7'd64});
    check(!tx_phase, "R8 tx_phase off at 64", tx_phase, 0);
  endtask

  task automatic t_transmit;
    logic [63:0] w;
    logic [7:0] got, exp;
    w[55:0] = {48'hA5A5_0F0F_3C3C, 8'h23};
    exp = ref_crc(w, 56);
    do_clear();
    for (int i = 0; i < 56; i++) send(w[i]);
    for (int i = 0; i < 8; i++) begin
      got[i] = tx_bit;
      send(tx_bit);
    end
    check(got == exp, "R8 sent crc", got, exp);
    check(code_ok && crc_q == 0, "R8 self ok", {code_ok, crc_q}, {1'b1, 8'h00});
  endtask

  initial begin
    rst = 1'b1; clr = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_known();
    t_family(48'h0000_0001_2345);
    t_family(48'hFFFF_FFFF_FFFF);
    t_corrupt();
    t_clear_prio();
    t_ignore();
    t_transmit();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule